// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the datapath of a small accumulator computer. A program counter, an address register, a 16-word RAM, an instruction register, two general registers (A and B) and an adder/subtractor all talk over one 8-bit internal bus. There is no sequencer inside. A 14-bit control word arrives from outside on every clock cycle, and each of its bits enables exactly one action: a unit driving the bus, or a unit capturing it. A control unit, or a testbench acting as one, builds instructions as short runs of such words.

Data can move from one unit to another only when a source's output-enable and a destination's load bit are set in the same cycle. An arithmetic result reaches A only if the ALU is explicitly gated onto the bus in the cycle that A loads. The block reports the ALU carry and zero flags, the opcode held in the upper nibble of the instruction register, and the current bus value.

The RAM takes its contents from a parameter image on every reset, so a program can be placed in it without a loading port.

Top module: `busdp_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the address register, the instruction register, A, B and both flags, and loads the RAM with the `MEM_IMAGE` parameter (word i is bits [8i+7:8i]).
- R2: The control-word bits are: 13 A drives, 12 A loads, 11 B drives, 10 B loads, 9 subtract select, 8 ALU drives, 7 PC loads, 6 PC drives, 5 PC increments, 4 address register loads, 3 RAM writes, 2 RAM drives, 1 instruction register loads, 0 operand drives. Each load captures the bus at the rising clock edge.
- R3: `bus_o` carries the value of the single enabled source. The PC and the operand (the low nibble of the instruction register) are zero-extended. With no source enabled the bus reads zero.
- R4: A fetch takes two cycles: PC drives while the address register loads, then the RAM drives while the instruction register loads. After that, `opcode_o` shows bits [7:4] of the fetched word.
- R5: PC increment counts modulo 16. PC load takes bus bits [3:0] and wins over an increment in the same cycle.
- R6: A RAM write stores the bus into the word addressed by the address register. A RAM drive puts that word on the bus.
- R7: The ALU result is A+B, or A−B (as A + ~B + 1) when subtract is selected. It appears on the bus only when the ALU-drive bit is set.
- R8: Carry holds the 9th bit of the ALU sum, which is not-borrow when subtracting. Zero is set when the 8-bit result is zero. Both flags change only in cycles with subtract select or ALU drive, so a subtract-only cycle updates the flags and leaves A unchanged.
- R9: An all-zero control word leaves every register, the PC, the flags and the RAM unchanged.
- R10: The sequence LDA 8, LDB 9, ADD, LDB 10, SUB, HLT with RAM[8]=10, RAM[9]=5 and RAM[10]=3 ends with A=12 and B=3.
- R11: Register-to-register copies (B drives while A loads, and the reverse) and a jump (operand drives while PC loads) move the source value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 14 | Control word for this cycle |
| opcode_o | output | 4 | Upper nibble of the instruction register |
| carry_o | output | 1 | ALU carry / not-borrow flag |
| zero_o | output | 1 | ALU zero flag |
| bus_o | output | 8 | Current value of the shared internal bus |

## Verification
The assertions take for granted that the control word never enables more than one bus source in a cycle. A control word that breaks this is an input error, and one assertion flags it; it is not a design fault. The bench keeps within this rule by composing every control word from a single drive bit plus any number of load, increment and select bits. It observes a register by enabling that register's drive bit alone and reading the bus before the next edge.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int CTL_W   = 14;
  localparam int B_A_OE  = 13;
  localparam int B_A_LD  = 12;
  localparam int B_B_OE  = 11;
  localparam int B_B_LD  = 10;
  localparam int B_SUB   = 9;
  localparam int B_ALU_OE= 8;
  localparam int B_PC_LD = 7;
  localparam int B_PC_OE = 6;
  localparam int B_PC_INC= 5;
  localparam int B_MAR_LD= 4;
  localparam int B_RAM_WE= 3;
  localparam int B_RAM_OE= 2;
  localparam int B_IR_LD = 1;
  localparam int B_IR_OE = 0;
  localparam int N_SRC   = 6;
endpackage

// File: rtl/bdp_bus_mux.sv
module bdp_bus_mux #(
  parameter int N  = 6,
  parameter int DW = 8
) (
  input  logic [N-1:0]         oe,
  input  logic [N-1:0][DW-1:0] src,
  output logic [DW-1:0]        bus
);
  logic [N:0][DW-1:0] chain;
  assign chain[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_src
    assign chain[i+1] = chain[i] | (src[i] & {DW{oe[i]}});
  end
  assign bus = chain[N];
endmodule

// File: rtl/bdp_pc.sv
module bdp_pc #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          inc,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)      pc <= '0;
    else if (ld)  pc <= din;
    else if (inc) pc <= pc + 1'b1;
  end
endmodule

// File: rtl/bdp_ram.sv
module bdp_ram #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [(2**AW)*DW-1:0] IMAGE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2**AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)                          mem[i] <= IMAGE[i*DW +: DW];
      else if (we && addr == AW'(i))    mem[i] <= wdata;
    end
  end
  assign rdata = mem[addr];
endmodule

// File: rtl/bdp_alu.sv
module bdp_alu #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          flag_en,
  output logic [DW-1:0] result,
  output logic          carry_q,
  output logic          zero_q
);
  function automatic logic [DW:0] add_sub(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic          s);
    logic [DW-1:0] yy;
    yy = s ? ~y : y;
    return {1'b0, x} + {1'b0, yy} + {{DW{1'b0}}, s};
  endfunction

  logic [DW:0] sum;
  assign sum    = add_sub(a, b, sub);
  assign result = sum[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (flag_en) begin
      carry_q <= sum[DW];
      zero_q  <= (sum[DW-1:0] == '0);
    end
  end
endmodule

// File: rtl/busdp_core.sv
module busdp_core
  import bdp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [(2**AW)*DW-1:0] MEM_IMAGE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] ctl,
  output logic [DW-AW-1:0] opcode_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic [DW-1:0]    bus_o
);
  localparam int OP_W = DW - AW;

  logic a_oe, a_ld, b_oe, b_ld, sub_sel, alu_oe;
  logic pc_ld, pc_oe, pc_inc, mar_ld, ram_we, ram_oe, ir_ld, ir_oe;
  assign a_oe    = ctl[B_A_OE];
  assign a_ld    = ctl[B_A_LD];
  assign b_oe    = ctl[B_B_OE];
  assign b_ld    = ctl[B_B_LD];
  assign sub_sel = ctl[B_SUB];
  assign alu_oe  = ctl[B_ALU_OE];
  assign pc_ld   = ctl[B_PC_LD];
  assign pc_oe   = ctl[B_PC_OE];
  assign pc_inc  = ctl[B_PC_INC];
  assign mar_ld  = ctl[B_MAR_LD];
  assign ram_we  = ctl[B_RAM_WE];
  assign ram_oe  = ctl[B_RAM_OE];
  assign ir_ld   = ctl[B_IR_LD];
  assign ir_oe   = ctl[B_IR_OE];

  logic [DW-1:0] bus_w, a_q, b_q, ir_q, alu_res, ram_rd;
  logic [AW-1:0] mar_q, pc_q;
  logic          carry_q, zero_q;

  logic [N_SRC-1:0]         src_oe;
  logic [N_SRC-1:0][DW-1:0] src_val;
  assign src_oe  = {ir_oe, ram_oe, pc_oe, alu_oe, b_oe, a_oe};
  assign src_val = {{{OP_W{1'b0}}, ir_q[AW-1:0]}, ram_rd,
                    {{OP_W{1'b0}}, pc_q}, alu_res, b_q, a_q};

  bdp_bus_mux #(.N(N_SRC), .DW(DW)) u_bus (
    .oe(src_oe), .src(src_val), .bus(bus_w)
  );

  bdp_pc #(.AW(AW)) u_pc (
    .clk(clk), .rst(rst), .ld(pc_ld), .inc(pc_inc),
    .din(bus_w[AW-1:0]), .pc(pc_q)
  );

  bdp_ram #(.DW(DW), .AW(AW), .IMAGE(MEM_IMAGE)) u_ram (
    .clk(clk), .rst(rst), .we(ram_we), .addr(mar_q),
    .wdata(bus_w), .rdata(ram_rd)
  );

  bdp_alu #(.DW(DW)) u_alu (
    .clk(clk), .rst(rst), .a(a_q), .b(b_q), .sub(sub_sel),
    .flag_en(sub_sel | alu_oe), .result(alu_res),
    .carry_q(carry_q), .zero_q(zero_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      ir_q  <= '0;
      mar_q <= '0;
    end else begin
      if (a_ld)   a_q   <= bus_w;
      if (b_ld)   b_q   <= bus_w;
      if (ir_ld)  ir_q  <= bus_w;
      if (mar_ld) mar_q <= bus_w[AW-1:0];
    end
  end

  assign opcode_o = ir_q[DW-1:AW];
  assign carry_o  = carry_q;
  assign zero_o   = zero_q;
  assign bus_o    = bus_w;
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker
  import bdp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [CTL_W-1:0] ctl,
  input logic [DW-1:0]    bus,
  input logic [DW-1:0]    a_q,
  input logic [DW-1:0]    b_q,
  input logic [AW-1:0]    pc_q,
  input logic [DW-1:0]    alu_res,
  input logic             carry_q,
  input logic             zero_q
);
  logic [5:0] oe_bits;
  assign oe_bits = {ctl[B_A_OE], ctl[B_B_OE], ctl[B_ALU_OE],
                    ctl[B_PC_OE], ctl[B_RAM_OE], ctl[B_IR_OE]};

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (rst) $countones(oe_bits) <= 1); // R3
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst) (oe_bits == '0) |-> (bus == '0)); // R3
  AST_A_CAPTURE: assert property (@(posedge clk) disable iff (rst) ctl[B_A_LD] |=> (a_q == $past(bus))); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) (ctl[B_PC_INC] && !ctl[B_PC_LD]) |=> (pc_q == AW'($past(pc_q) + 1'b1))); // R5
  AST_ALU_DRIVE: assert property (@(posedge clk) disable iff (rst) ctl[B_ALU_OE] |-> (bus == alu_res)); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) (!ctl[B_SUB] && !ctl[B_ALU_OE]) |=> $stable({carry_q, zero_q})); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (ctl == '0) |=> ($stable(a_q) && $stable(b_q) && $stable(pc_q))); // R9
endmodule

bind busdp_core bdp_checker #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .ctl(ctl), .bus(bus_w), .a_q(a_q), .b_q(b_q),
  .pc_q(pc_q), .alu_res(alu_res), .carry_q(carry_q), .zero_q(zero_q)
);

// File: tb/busdp_core_tb_top.sv
module busdp_core_tb_top;
  localparam logic [13:0] A_OE = 14'h2000, A_LD = 14'h1000, B_OE = 14'h0800,
    B_LD = 14'h0400, SUB = 14'h0200, ALU_OE = 14'h0100, PC_LD = 14'h0080,
    PC_OE = 14'h0040, PC_INC = 14'h0020, MAR_LD = 14'h0010, RAM_WE = 14'h0008,
    RAM_OE = 14'h0004, IR_LD = 14'h0002, IR_OE = 14'h0001;

  function automatic logic [127:0] build_image();
    logic [7:0] w [16];
    logic [127:0] img;
    w[0] = 8'h18; w[1] = 8'h59; w[2] = 8'h30; w[3] = 8'h5A;
    w[4] = 8'hC0; w[5] = 8'hF0; w[6] = 8'h8D; w[7] = 8'h00;
    w[8] = 8'd10; w[9] = 8'd5;  w[10] = 8'd3; w[11] = 8'h00;
    w[12] = 8'hFF; w[13] = 8'h2E; w[14] = 8'h00; w[15] = 8'h5C;
    for (int i = 0; i < 16; i++) img[i*8 +: 8] = w[i];
    return img;
  endfunction
  localparam logic [127:0] IMG = build_image();

  logic clk = 1'b0, rst = 1'b1;
  logic [13:0] ctl = '0;
  logic [3:0] opcode_o;
  logic carry_o, zero_o;
  logic [7:0] bus_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  busdp_core #(.MEM_IMAGE(IMG)) dut_i (
    .clk(clk), .rst(rst), .ctl(ctl), .opcode_o(opcode_o),
    .carry_o(carry_o), .zero_o(zero_o), .bus_o(bus_o)
  );

  function automatic logic [8:0] model_alu(input logic [7:0] x, input logic [7:0] y, input bit s);
    int r;
    r = s ? (int'(x) - int'(y) + 256) : (int'(x) + int'(y));
    return r[8:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] c);
    ctl = c;
    @(negedge clk);
    ctl = '0;
  endtask

  task automatic peek(input logic [13:0] oe, output logic [7:0] v);
    ctl = oe;
    #1;
    v = bus_o;
    ctl = '0;
  endtask

  task automatic fetch();
    step(PC_OE | MAR_LD);
    step(RAM_OE | IR_LD | PC_INC);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R3 idle bus", bus_o, 0);
    peek(A_OE, v);  chk("R1 A after reset", v, 0);
    peek(B_OE, v);  chk("R1 B after reset", v, 0);
    peek(PC_OE, v); chk("R1 PC after reset", v, 0);
    peek(IR_OE, v); chk("R1 IR after reset", v, 0);
    chk("R1 opcode after reset", opcode_o, 0);
    chk("R1 flags after reset", {carry_o, zero_o}, 0);
  endtask

  task automatic t_program();
    logic [7:0] v;
    logic [8:0] m;
    fetch();
    chk("R4 opcode LDA", opcode_o, 4'h1);
    peek(IR_OE, v); chk("R3 operand zero-extended", v, 8);
    peek(PC_OE, v); chk("R5 PC after fetch", v, 1);
    step(IR_OE | MAR_LD); step(RAM_OE | A_LD);
    peek(A_OE, v); chk("R6 LDA 8 into A", v, 10);
    fetch(); step(IR_OE | MAR_LD); step(RAM_OE | B_LD);
    peek(B_OE, v); chk("R6 LDB 9 into B", v, 5);
    fetch(); chk("R4 opcode ADD", opcode_o, 4'h3);
    m = model_alu(8'd10, 8'd5, 1'b0);
    step(ALU_OE | A_LD);
    peek(A_OE, v); chk("R7 ADD result", v, m[7:0]);
    chk("R8 carry after ADD", carry_o, m[8]);
    fetch(); step(IR_OE | MAR_LD); step(RAM_OE | B_LD);
    fetch(); chk("R4 opcode SUB", opcode_o, 4'hC);
    m = model_alu(8'd15, 8'd3, 1'b1);
    step(SUB | ALU_OE | A_LD);
    chk("R8 not-borrow after SUB", carry_o, m[8]);
    chk("R8 zero clear after SUB", zero_o, 0);
    fetch(); chk("R4 opcode HLT", opcode_o, 4'hF);
    peek(A_OE, v); chk("R10 final A", v, 12);
    peek(B_OE, v); chk("R10 final B", v, 3);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    logic [1:0] fl;
    fl = {carry_o, zero_o};
    step('0); step('0); step('0);
    peek(A_OE, v);  chk("R9 A held", v, 12);
    peek(B_OE, v);  chk("R9 B held", v, 3);
    peek(PC_OE, v); chk("R9 PC held", v, 6);
    chk("R9 flags held", {carry_o, zero_o}, fl);
    chk("R9 opcode held", opcode_o, 4'hF);
  endtask

  task automatic t_jump_copy_cmp();
    logic [7:0] v;
    fetch();
    chk("R4 opcode JMP", opcode_o, 4'h8);
    step(IR_OE | PC_LD | PC_INC);
    peek(PC_OE, v); chk("R11 JMP target, R5 load wins", v, 13);
    step(B_OE | A_LD);
    peek(A_OE, v); chk("R11 B copied to A", v, 3);
    step(SUB);
    peek(A_OE, v); chk("R8 compare leaves A", v, 3);
    chk("R8 zero set on equal compare", zero_o, 1);
    chk("R8 carry set on equal compare", carry_o, 1);
    step(A_OE | B_LD);
    peek(B_OE, v); chk("R11 A copied to B", v, 3);
    chk("R8 flags hold on copy", {carry_o, zero_o}, 2'b11);
  endtask

  task automatic t_store_wrap();
    logic [7:0] v;
    logic [8:0] m;
    fetch(); chk("R4 opcode STA", opcode_o, 4'h2);
    step(IR_OE | MAR_LD); step(A_OE | RAM_WE);
    step(IR_OE | MAR_LD);
    peek(RAM_OE, v); chk("R6 stored word read back", v, 3);
    fetch(); chk("R6 stored word fetched as opcode", opcode_o, 4'h0);
    fetch(); chk("R4 opcode LDB", opcode_o, 4'h5);
    peek(PC_OE, v); chk("R5 PC wraps to 0", v, 0);
    step(IR_OE | MAR_LD); step(RAM_OE | B_LD);
    m = model_alu(8'd3, 8'hFF, 1'b0);
    peek(ALU_OE, v); chk("R7 ALU on bus when driven", v, m[7:0]);
    step(ALU_OE);
    peek(A_OE, v); chk("R7 A unchanged without load", v, 3);
    chk("R8 carry out of ADD", carry_o, m[8]);
    step(ALU_OE | A_LD);
    m = model_alu(8'd2, 8'hFF, 1'b1);
    step(SUB | ALU_OE | A_LD);
    peek(A_OE, v); chk("R7 SUB with wrap", v, m[7:0]);
    chk("R8 borrow clears carry", carry_o, m[8]);
  endtask

  task automatic t_rereset();
    logic [7:0] v;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    peek(A_OE, v);  chk("R1 A cleared by reset", v, 0);
    peek(PC_OE, v); chk("R1 PC cleared by reset", v, 0);
    chk("R1 flags cleared by reset", {carry_o, zero_o}, 0);
    fetch(); chk("R1 RAM image after reset", opcode_o, 4'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_idle();
    t_jump_copy_cmp();
    t_store_wrap();
    t_rereset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule